// File: doc/BRIEF.md
# Strided Scratch-Memory Block Mover

This engine copies data between a two-bank local scratch memory, 4 KB per bank, and a larger external DRAM. Software first stages a local start address and a DRAM start address. It then writes one of two length registers. A write to the read-length register copies from DRAM into local memory. A write to the write-length register copies from local memory into DRAM.

Each transfer is a two-dimensional pattern. It moves a number of rows, each of a fixed byte length, and between rows it jumps ahead in DRAM by a skip distance. The local side is packed and wraps inside its bank. DRAM addresses that fall past the configured DRAM size are filled with zero on reads and dropped on writes. When the transfer ends, the engine writes the end addresses back into its visible address registers and resets the low part of both length registers.

The engine moves 8 bytes per beat, one beat per clock cycle. It drives one synchronous single-port memory port toward each side, and both ports have one cycle of read latency.

Top module: `strided_dma`

## Requirements
- R1: `reg_sel` codes are 0 for the staged local address, 1 for the staged DRAM address, 2 for the read length and 3 for the write length. Staged address writes change no visible register and start nothing. A length write while idle starts a transfer: code 2 moves DRAM to local, and code 3 moves local to DRAM.
- R2: The DRAM start address is the staged value ANDed with 0xFFFFF8, so it is 24 bits and 8-byte aligned. The local start offset is the staged value ANDed with 0xFF8. Staged bit 12 picks the bank: 1 is the instruction bank (`lcl_bank`=1) and 0 is the data bank.
- R3: In a length word, bits [11:0] give the row length as (field OR 7)+1 bytes, bits [19:12] give the row count as field+1, and bits [31:20] ANDed with 0xFF8 give the skip in bytes.
- R4: The local offset wraps from 0xFFF back to 0 inside the same bank, even in the middle of a row. The DRAM address wraps modulo 2^24.
- R5: On a DRAM-to-local transfer, a beat whose DRAM address is at or above `DRAM_SIZE` writes zero into local memory.
- R6: On a local-to-DRAM transfer, a beat whose DRAM address is at or above `DRAM_SIZE` is dropped, and DRAM is never written at that address.
- R7: After each row the DRAM address moves forward by the row length plus the skip. When the count is above one, the last skip is taken back before writeback. A single-row transfer keeps its skip.
- R8: On completion, `loc_addr_o` holds the original bank bit in bit 12 and the final 12-bit local offset below it. `dram_addr_o` holds the final DRAM address.
- R9: On completion, both length registers keep bits [31:23] and have bits [22:0] set to 0x000FF8.
- R10: `busy_o` and `dma_busy_o` are both high from the cycle after the start until the writeback edge. `done_o` is a one-cycle pulse in the cycle the written-back values first show. Reset clears every register to 0.
- R11: A length write that arrives while a transfer runs is ignored. It does not change the length register and it does not start a transfer.
- R12: A transfer of N beats keeps the engine busy for exactly N+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select code |
| reg_wdata | input | 32 | Register write data |
| loc_addr_o | output | 13 | Visible local address register (bank bit and offset) |
| dram_addr_o | output | 24 | Visible DRAM address register |
| rd_len_o | output | 32 | Read-length register |
| wr_len_o | output | 32 | Write-length register |
| busy_o | output | 1 | Busy status bit |
| dma_busy_o | output | 1 | Separate DMA-busy register |
| done_o | output | 1 | Completion pulse |
| lcl_en | output | 1 | Local memory access enable |
| lcl_we | output | 1 | Local memory write enable |
| lcl_bank | output | 1 | Local bank select, 1 is instruction |
| lcl_addr | output | 9 | Local 8-byte word address |
| lcl_wdata | output | 64 | Local write data |
| lcl_rdata | input | 64 | Local read data, one cycle after a read |
| dram_en | output | 1 | DRAM access enable |
| dram_we | output | 1 | DRAM write enable |
| dram_addr | output | 21 | DRAM 8-byte word address |
| dram_wdata | output | 64 | DRAM write data |
| dram_rdata | input | 64 | DRAM read data, one cycle after a read |

## Verification
The assertions check five rules on every cycle. A length write while idle always raises busy. Done is a single pulse that never overlaps busy. A length write during a running transfer leaves the register unchanged. No DRAM write ever targets an address past the configured size. The length registers show 0xFF8 in their low bits when done rises.

Three things can only be shown by the bench's scenarios: the actual memory contents after strided, wrapping and zero-filled transfers, the arithmetic of the final addresses including the single-row skip, and the exact busy duration. The bench shows them by comparing whole memory images and register values against an independent model.

// File: rtl/strided_dma_pkg.sv
package strided_dma_pkg;
    // register select codes
    localparam logic [1:0] SEL_LOC   = 2'd0;
    localparam logic [1:0] SEL_DRAM  = 2'd1;
    localparam logic [1:0] SEL_RDLEN = 2'd2;
    localparam logic [1:0] SEL_WRLEN = 2'd3;

    // length word field positions
    localparam int CNT_LO  = 12;
    localparam int CNT_W   = 8;
    localparam int SKIP_LO = 20;
    localparam int SKIP_W  = 12;
    localparam int KEEP_LO = 23;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } dma_state_e;
endpackage

// File: rtl/sdma_len_decode.sv
module sdma_len_decode
    import strided_dma_pkg::*;
#(
    parameter int LCL_OFF_W = 12,
    parameter int BS        = 3,
    localparam int BCW      = LCL_OFF_W - BS
) (
    input  logic [31:0]       len_word,
    output logic [BCW-1:0]    beats_m1,
    output logic [CNT_W-1:0]  rows_m1,
    output logic [SKIP_W-1:0] skip
);
    localparam logic [LCL_OFF_W-1:0] LO_ONES = LCL_OFF_W'((1 << BS) - 1);

    logic [LCL_OFF_W:0] row_bytes;

    always_comb begin
        row_bytes = {1'b0, len_word[LCL_OFF_W-1:0] | LO_ONES} + (LCL_OFF_W+1)'(1);
        beats_m1  = BCW'(row_bytes >> BS) - BCW'(1);
        rows_m1   = len_word[CNT_LO +: CNT_W];
        skip      = len_word[SKIP_LO +: SKIP_W] & ~SKIP_W'((1 << BS) - 1);
    end
endmodule

// File: rtl/sdma_beat_pipe.sv
module sdma_beat_pipe #(
    parameter int AW = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW-1:0] in_addr,
    input  logic          in_zero,
    output logic          out_valid,
    output logic [AW-1:0] out_addr,
    output logic          out_zero
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_zero  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_addr  <= in_addr;
            out_zero  <= in_zero;
        end
    end
endmodule

// File: rtl/strided_dma.sv
module strided_dma
    import strided_dma_pkg::*;
#(
    parameter int          LCL_OFF_W = 12,
    parameter int          DRAM_AW   = 24,
    parameter int          DW        = 64,
    parameter int unsigned DRAM_SIZE = 32'h0080_0000,
    localparam int BS      = $clog2(DW / 8),
    localparam int LWORD_W = LCL_OFF_W - BS,
    localparam int DWORD_W = DRAM_AW - BS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [1:0]           reg_sel,
    input  logic [31:0]          reg_wdata,
    output logic [LCL_OFF_W:0]   loc_addr_o,
    output logic [DRAM_AW-1:0]   dram_addr_o,
    output logic [31:0]          rd_len_o,
    output logic [31:0]          wr_len_o,
    output logic                 busy_o,
    output logic                 dma_busy_o,
    output logic                 done_o,
    output logic                 lcl_en,
    output logic                 lcl_we,
    output logic                 lcl_bank,
    output logic [LWORD_W-1:0]   lcl_addr,
    output logic [DW-1:0]        lcl_wdata,
    input  logic [DW-1:0]        lcl_rdata,
    output logic                 dram_en,
    output logic                 dram_we,
    output logic [DWORD_W-1:0]   dram_addr,
    output logic [DW-1:0]        dram_wdata,
    input  logic [DW-1:0]        dram_rdata
);
    localparam logic [LCL_OFF_W-1:0] OFF_MASK  = ~LCL_OFF_W'((1 << BS) - 1);
    localparam logic [DRAM_AW-1:0]   DRAM_MASK = ~DRAM_AW'((1 << BS) - 1);
    localparam logic [DRAM_AW-1:0]   BEAT_STEP = DRAM_AW'(1 << BS);
    localparam logic [22:0]          LEN_RESET = 23'h000FF8;

    typedef struct packed {
        dma_state_e           st;
        logic                 dir_wr;
        logic                 bank;
        logic [LCL_OFF_W-1:0] loc_off;
        logic [DRAM_AW-1:0]   dram;
        logic [LWORD_W-1:0]   beat;
        logic [CNT_W-1:0]     row;
        logic [LWORD_W-1:0]   beats_m1;
        logic [CNT_W-1:0]     rows_m1;
        logic [SKIP_W-1:0]    skip;
        logic [LCL_OFF_W:0]   stg_loc;
        logic [DRAM_AW-1:0]   stg_dram;
        logic [LCL_OFF_W:0]   loc_vis;
        logic [DRAM_AW-1:0]   dram_vis;
        logic [31:0]          rd_len;
        logic [31:0]          wr_len;
        logic                 busy;
        logic                 dma_busy;
        logic                 done;
    } regs_t;

    regs_t r_q, r_d;

    logic [LWORD_W-1:0] dec_beats_m1;
    logic [CNT_W-1:0]   dec_rows_m1;
    logic [SKIP_W-1:0]  dec_skip;
    logic               beyond;
    logic               run;
    logic               p_valid, p_zero;
    logic [DWORD_W-1:0] p_addr;
    logic               in_valid;
    logic [DWORD_W-1:0] in_addr;

    sdma_len_decode #(.LCL_OFF_W(LCL_OFF_W), .BS(BS)) u_dec (
        .len_word (reg_wdata),
        .beats_m1 (dec_beats_m1),
        .rows_m1  (dec_rows_m1),
        .skip     (dec_skip)
    );

    assign run      = (r_q.st == ST_RUN);
    assign beyond   = (32'(r_q.dram) >= DRAM_SIZE);
    assign in_valid = run && !(r_q.dir_wr && beyond);
    assign in_addr  = r_q.dir_wr ? r_q.dram[DRAM_AW-1:BS]
                                 : DWORD_W'(r_q.loc_off[LCL_OFF_W-1:BS]);

    sdma_beat_pipe #(.AW(DWORD_W)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_addr   (in_addr),
        .in_zero   (beyond),
        .out_valid (p_valid),
        .out_addr  (p_addr),
        .out_zero  (p_zero)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (reg_we) begin
            case (reg_sel)
                SEL_LOC:  r_d.stg_loc  = reg_wdata[LCL_OFF_W:0];
                SEL_DRAM: r_d.stg_dram = reg_wdata[DRAM_AW-1:0];
                default: begin
                    if (r_q.st == ST_IDLE) begin
                        if (reg_sel == SEL_RDLEN) r_d.rd_len = reg_wdata;
                        else                      r_d.wr_len = reg_wdata;
                        r_d.dir_wr   = (reg_sel == SEL_WRLEN);
                        r_d.bank     = r_q.stg_loc[LCL_OFF_W];
                        r_d.loc_off  = r_q.stg_loc[LCL_OFF_W-1:0] & OFF_MASK;
                        r_d.dram     = r_q.stg_dram & DRAM_MASK;
                        r_d.beats_m1 = dec_beats_m1;
                        r_d.rows_m1  = dec_rows_m1;
                        r_d.skip     = dec_skip;
                        r_d.beat     = '0;
                        r_d.row      = '0;
                        r_d.st       = ST_RUN;
                        r_d.busy     = 1'b1;
                        r_d.dma_busy = 1'b1;
                    end
                end
            endcase
        end
        case (r_q.st)
            ST_RUN: begin
                r_d.loc_off = r_q.loc_off + LCL_OFF_W'(1 << BS);
                if (r_q.beat == r_q.beats_m1) begin
                    r_d.beat = '0;
                    if (r_q.row == r_q.rows_m1) begin
                        r_d.st   = ST_FLUSH;
                        r_d.dram = r_q.dram + BEAT_STEP +
                                   ((r_q.rows_m1 == '0) ? DRAM_AW'(r_q.skip) : '0);
                    end else begin
                        r_d.row  = r_q.row + CNT_W'(1);
                        r_d.dram = r_q.dram + BEAT_STEP + DRAM_AW'(r_q.skip);
                    end
                end else begin
                    r_d.beat = r_q.beat + LWORD_W'(1);
                    r_d.dram = r_q.dram + BEAT_STEP;
                end
            end
            ST_FLUSH: begin
                r_d.st       = ST_IDLE;
                r_d.loc_vis  = {r_q.bank, r_q.loc_off};
                r_d.dram_vis = r_q.dram;
                r_d.rd_len   = {r_q.rd_len[31:KEEP_LO], LEN_RESET};
                r_d.wr_len   = {r_q.wr_len[31:KEEP_LO], LEN_RESET};
                r_d.busy     = 1'b0;
                r_d.dma_busy = 1'b0;
                r_d.done     = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign loc_addr_o  = r_q.loc_vis;
    assign dram_addr_o = r_q.dram_vis;
    assign rd_len_o    = r_q.rd_len;
    assign wr_len_o    = r_q.wr_len;
    assign busy_o      = r_q.busy;
    assign dma_busy_o  = r_q.dma_busy;
    assign done_o      = r_q.done;

    assign lcl_bank   = r_q.bank;
    assign lcl_we     = p_valid && !r_q.dir_wr;
    assign lcl_en     = (run && r_q.dir_wr) || lcl_we;
    assign lcl_addr   = lcl_we ? p_addr[LWORD_W-1:0] : r_q.loc_off[LCL_OFF_W-1:BS];
    assign lcl_wdata  = p_zero ? '0 : dram_rdata;
    assign dram_we    = p_valid && r_q.dir_wr;
    assign dram_en    = (run && !r_q.dir_wr && !beyond) || dram_we;
    assign dram_addr  = dram_we ? p_addr : r_q.dram[DRAM_AW-1:BS];
    assign dram_wdata = lcl_rdata;

    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && reg_we && reg_sel[1]) |=> busy_o);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !dma_busy_o));
    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && reg_we && reg_sel == SEL_WRLEN) |=> $stable(wr_len_o));
    // R6
    dram_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dram_we |-> (32'({dram_addr, {BS{1'b0}}}) < DRAM_SIZE));
    // R9
    len_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (rd_len_o[22:0] == LEN_RESET && wr_len_o[22:0] == LEN_RESET));
endmodule

// File: tb/strided_dma_bench.sv
`timescale 1ns/1ps
module strided_dma_bench;
    localparam int unsigned DSIZE = 32'h800;
    localparam int DWORDS = DSIZE / 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [12:0] loc_addr_o;
    logic [23:0] dram_addr_o;
    logic [31:0] rd_len_o, wr_len_o;
    logic        busy_o, dma_busy_o, done_o;
    logic        lcl_en, lcl_we, lcl_bank;
    logic [8:0]  lcl_addr;
    logic [63:0] lcl_wdata, lcl_rdata;
    logic        dram_en, dram_we;
    logic [20:0] dram_addr;
    logic [63:0] dram_wdata, dram_rdata;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    strided_dma #(.DRAM_SIZE(DSIZE)) u_strided_dma (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .loc_addr_o(loc_addr_o), .dram_addr_o(dram_addr_o), .rd_len_o(rd_len_o),
        .wr_len_o(wr_len_o), .busy_o(busy_o), .dma_busy_o(dma_busy_o), .done_o(done_o),
        .lcl_en(lcl_en), .lcl_we(lcl_we), .lcl_bank(lcl_bank), .lcl_addr(lcl_addr),
        .lcl_wdata(lcl_wdata), .lcl_rdata(lcl_rdata), .dram_en(dram_en), .dram_we(dram_we),
        .dram_addr(dram_addr), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
    );

    logic [63:0] lm [2][512];
    logic [63:0] dm [DWORDS];
    logic [63:0] xlm [2][512];
    logic [63:0] xdm [DWORDS];

    always @(posedge clk) begin
        if (lcl_en) begin
            if (lcl_we) lm[lcl_bank][lcl_addr] <= lcl_wdata;
            else        lcl_rdata <= lm[lcl_bank][lcl_addr];
        end
        if (dram_en) begin
            if (dram_we) dm[dram_addr[7:0]] <= dram_wdata;
            else         dram_rdata <= dm[dram_addr[7:0]];
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cmp_mem(string tag);
        int bad_l = 0;
        int bad_d = 0;
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 512; i++)
                if (lm[b][i] !== xlm[b][i]) bad_l++;
        for (int i = 0; i < DWORDS; i++)
            if (dm[i] !== xdm[i]) bad_d++;
        chk({tag, " local image"}, 64'(bad_l), 64'd0);
        chk({tag, " dram image"}, 64'(bad_d), 64'd0);
    endtask

    // independent model built from R2..R7
    task automatic ref_run(logic wr, logic [31:0] m, logic [31:0] d, logic [31:0] l,
                           output int beats);
        int bank = int'(m[12]);
        int off  = int'(m & 32'h0FF8);
        int da   = int'(d & 32'h00FF_FFF8);
        int len  = int'((l[11:0] | 12'h7)) + 1;
        int cnt  = int'(l[19:12]) + 1;
        int skp  = int'(l[31:20] & 12'hFF8);
        beats = 0;
        for (int r = 0; r < cnt; r++) begin
            for (int b = 0; b < len / 8; b++) begin
                if (!wr) xlm[bank][off/8] = (da < int'(DSIZE)) ? xdm[da/8] : 64'd0;
                else if (da < int'(DSIZE)) xdm[da/8] = xlm[bank][off/8];
                off = (off + 8) & 32'hFFF;
                da  = (da + 8) & 32'hFF_FFFF;
                beats++;
            end
            da = (da + skp) & 32'hFF_FFFF;
        end
    endtask

    task automatic wr_reg(logic [1:0] s, logic [31:0] v);
        reg_we = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic do_xfer(logic wr, logic [31:0] m, logic [31:0] d, logic [31:0] l,
                           logic inject, output int busy_cnt);
        int guard = 0;
        wr_reg(2'd0, m);
        wr_reg(2'd1, d);
        wr_reg(wr ? 2'd3 : 2'd2, l);
        busy_cnt = 0;
        while (busy_o && guard < 5000) begin
            chk("R10 dma_busy tracks busy", 64'(dma_busy_o), 64'd1);
            if (inject && busy_cnt == 0) begin
                reg_we = 1'b1; reg_sel = 2'd3; reg_wdata = 32'hFFFF_FFFF;
            end else begin
                reg_we = 1'b0;
            end
            busy_cnt++;
            guard++;
            @(negedge clk);
        end
        reg_we = 1'b0;
        chk("R10 done pulse at writeback", 64'(done_o), 64'd1);
    endtask

    typedef struct packed {
        logic        wr;
        logic [31:0] m;
        logic [31:0] d;
        logic [31:0] l;
        logic [12:0] eloc;
        logic [23:0] edram;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 32'h0000_0010, 32'h0000_0100, 32'h0000_000F, 13'h0020, 24'h000110},
        '{1'b0, 32'hABC0_1105, 32'hFF00_0203, 32'h01F0_2008, 13'h1130, 24'h000260},
        '{1'b1, 32'h0000_0040, 32'h0000_0300, 32'h0100_000F, 13'h0050, 24'h000320},
        '{1'b0, 32'h0000_1FF0, 32'h0000_0080, 32'h0000_001F, 13'h1010, 24'h0000A0},
        '{1'b0, 32'h0000_0200, 32'h0000_07F0, 32'h0000_001F, 13'h0220, 24'h000810},
        '{1'b1, 32'h0000_0300, 32'h0000_07F8, 32'h0000_000F, 13'h0310, 24'h000808},
        '{1'b0, 32'h0000_0400, 32'h00FF_FFF8, 32'h0000_000F, 13'h0410, 24'h000008},
        '{1'b1, 32'h0000_1800, 32'h0000_0400, 32'h0200_1017, 13'h1830, 24'h000450}
    };

    initial begin
        int nb;
        int bc;
        logic [31:0] xrd;
        logic [31:0] xwr;
        xrd = 32'd0;
        xwr = 32'd0;
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 512; i++) begin
                lm[b][i]  = {16'(b), 16'(i), 32'hC0DE_0000 ^ 32'(i * 7)};
                xlm[b][i] = lm[b][i];
            end
        for (int i = 0; i < DWORDS; i++) begin
            dm[i]  = {32'hDA7A_0000 | 32'(i), 32'(i * 3 + 1)};
            xdm[i] = dm[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R10)
        chk("R10 reset busy", 64'(busy_o), 64'd0);
        chk("R10 reset done", 64'(done_o), 64'd0);
        chk("R10 reset loc_addr", 64'(loc_addr_o), 64'd0);
        chk("R10 reset len", 64'(rd_len_o | wr_len_o), 64'd0);

        // R1: staged writes alone do nothing visible
        wr_reg(2'd0, 32'h0000_1234);
        wr_reg(2'd1, 32'h0000_0555);
        repeat (3) @(negedge clk);
        chk("R1 staged loc not visible", 64'(loc_addr_o), 64'd0);
        chk("R1 staged dram not visible", 64'(dram_addr_o), 64'd0);
        chk("R1 staged write starts nothing", 64'(busy_o), 64'd0);
        cmp_mem("R1 staged");

        // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R12
        foreach (VECS[k]) begin
            ref_run(VECS[k].wr, VECS[k].m, VECS[k].d, VECS[k].l, nb);
            if (VECS[k].wr) xwr = VECS[k].l; else xrd = VECS[k].l;
            xrd = {xrd[31:23], 23'h000FF8};
            xwr = {xwr[31:23], 23'h000FF8};
            do_xfer(VECS[k].wr, VECS[k].m, VECS[k].d, VECS[k].l, 1'b0, bc);
            chk("R8 local end address", 64'(loc_addr_o), 64'(VECS[k].eloc));
            chk("R7 dram end address", 64'(dram_addr_o), 64'(VECS[k].edram));
            chk("R9 read length writeback", 64'(rd_len_o), 64'(xrd));
            chk("R9 write length writeback", 64'(wr_len_o), 64'(xwr));
            chk("R12 busy cycles", 64'(bc), 64'(nb + 1));
            cmp_mem("R2 R4 R5 R6 data");
            @(negedge clk);
            chk("R10 done one cycle", 64'(done_o), 64'd0);
        end

        // R11: write-length write during a read transfer is ignored
        ref_run(1'b0, 32'h0000_0600, 32'h0000_0040, 32'h0000_003F, nb);
        xrd = {32'h0000_003F & 32'hFF80_0000, 23'h000FF8};
        xwr = {xwr[31:23], 23'h000FF8};
        do_xfer(1'b0, 32'h0000_0600, 32'h0000_0040, 32'h0000_003F, 1'b1, bc);
        chk("R11 busy cycles unchanged", 64'(bc), 64'(nb + 1));
        chk("R11 write length not loaded", 64'(wr_len_o), 64'(xwr));
        chk("R11 read length writeback", 64'(rd_len_o), 64'(xrd));
        repeat (4) @(negedge clk);
        chk("R11 no second transfer", 64'(busy_o), 64'd0);
        cmp_mem("R11 data");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R12 actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule